// File: doc/BRIEF.md
# Quad UART bus interface glue

This block connects the external memory bus of a 32-bit floating-point DSP to an external device that holds four 16550-style UART channels. When a DSP bus cycle falls inside a programmable address window, the block drives an active-low chip select for one of the four channels. It also drives an active-low read strobe or write strobe for a fixed number of clocks, then returns a one-cycle ready pulse to the DSP. The three lowest address bits and the byte-wide data path are wired directly between the DSP and the UART device. This block only produces the control signals.

The block combines the four channel interrupt lines into one DSP interrupt through a 4-bit enable mask. A small control window at a fixed address holds the window base register and the mask register. The same window offers a read-only view of which channel lines are pending. Both registers clear on reset, so no channel can be selected and no interrupt can reach the DSP until software sets them up.

Top module: `quad_uart_glue`

## Requirements
- R1: After reset, all four chip selects, the read strobe and the write strobe are high. The ready output and the interrupt output are low. The base register and the mask register read back as zero.
- R2: No chip select, strobe or ready is produced when either of these holds: the base register is zero, or address bits 23 to 5 differ from the base register.
- R3: A channel access needs two things: the external strobe sampled low, and address bits 23 to 5 equal to a nonzero base register. The channel chip select is then selected by address bits 4 to 3 (value 0 is channel A on chip select bit 0, value 3 is channel D on bit 3). Only that chip select goes low, and address bits 2 to 0 do not change the choice.
- R4: A channel access with the read/write input at 1 drives only the read strobe low. With the input at 0, it drives only the write strobe low. The two strobes are never low together.
- R5: The chip select and the strobe stay low for exactly WAIT_STATES clocks (default 3). They start in the cycle after the clock edge that first samples the external strobe low.
- R6: The ready output is high for exactly one cycle. For a channel access, that cycle comes right after the last strobe cycle. For a control-window access, it comes in the cycle after the strobe is sampled.
- R7: Holding the external strobe low after ready does not start a second access. The next access can only begin after the external strobe has been seen high.
- R8: The control window is the four addresses whose bits 23 to 2 equal CTRL_ADDR bits 23 to 2, and address bits 1 to 0 select the offset. Offset 0 is the base register (data bits 18 to 0), offset 1 is the interrupt mask (data bits 3 to 0), and offset 3 reads as zero. On a read, the register value appears zero-extended on the read data output while ready is high.
- R9: A read at offset 2 returns the raw channel interrupt lines, with channel A in bit 0. A write to offset 2 or offset 3 changes neither register.
- R10: The interrupt output is high exactly when some channel's interrupt line and that channel's mask bit are both high.
- R11: The control window takes priority over the channel window. An access to a control address makes no chip select go low, even when the base register equals the control address bits 23 to 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | DSP bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 24 | DSP external address |
| bus_strb_n | input | 1 | DSP external bus strobe, active low |
| bus_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_wdata | input | 19 | Low DSP data bits used for control-window writes |
| bus_rdata | output | 32 | Control-window read data, valid while bus_ready is high |
| bus_ready | output | 1 | One-cycle access-complete pulse to the DSP |
| uart_cs_n | output | 4 | Per-channel chip selects, active low, channel A in bit 0 |
| uart_rd_n | output | 1 | UART read strobe, active low |
| uart_wr_n | output | 1 | UART write strobe, active low |
| uart_irq | input | 4 | Per-channel interrupt lines, active high, channel A in bit 0 |
| dsp_irq | output | 1 | Combined masked interrupt to the DSP |

## Verification
The bench counts the strobe and chip-select cycles of every access and records the cycle in which ready appears. A design with an off-by-one wait counter would show two or four strobe cycles, or ready in the wrong place. It holds the external strobe low well beyond ready, so a design that starts a second access on a held strobe shows up as doubled counts. It sweeps all four channel codes with different low address bits, and it tries addresses one step above and below the window. A swapped channel decode or a sloppy upper compare would light the wrong chip select or answer a foreign address. Finally, it sets the base register to the control window's own upper bits, and it writes to the read-only pending offset. A design with the wrong priority would select a UART on a control read, and a design with bad write decode would corrupt the mask or base register.

// File: rtl/quart_pkg.sv
package quart_pkg;

    localparam int NUM_CH = 4;

    localparam logic [1:0] OFS_BASE = 2'd0;
    localparam logic [1:0] OFS_MASK = 2'd1;
    localparam logic [1:0] OFS_PEND = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STROBE,
        ST_ACK,
        ST_HOLD
    } cyc_state_t;

    typedef struct packed {
        logic       uart_hit;
        logic       ctrl_hit;
        logic [1:0] chan;
        logic [1:0] ofs;
    } dec_t;

    function automatic logic [NUM_CH-1:0] chan_onehot(input logic [1:0] c);
        logic [NUM_CH-1:0] v;
        v = '0;
        v[c] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/quart_decode.sv
module quart_decode
    import quart_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 24'hFFFFF0,
    localparam int BASE_W = ADDR_W - 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              strb_n,
    input  logic [BASE_W-1:0] base,
    output dec_t              dec
);

    logic ctrl_match;
    logic win_match;

    always_comb begin
        ctrl_match   = (addr[ADDR_W-1:2] == CTRL_ADDR[ADDR_W-1:2]);
        win_match    = (base != '0) && (addr[ADDR_W-1:5] == base);
        dec.ctrl_hit = !strb_n && ctrl_match;
        dec.uart_hit = !strb_n && win_match && !ctrl_match;
        dec.chan     = addr[4:3];
        dec.ofs      = addr[1:0];
    end

endmodule

// File: rtl/quart_cfg_regs.sv
module quart_cfg_regs
    import quart_pkg::*;
#(
    parameter int BASE_W = 19,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        ofs,
    input  logic [BASE_W-1:0] wdata,
    input  logic [NUM_CH-1:0] irq_lines,
    output logic [BASE_W-1:0] base,
    output logic [NUM_CH-1:0] mask,
    output logic [DATA_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            base  <= '0;
            mask  <= '0;
            rdata <= '0;
        end else begin
            if (wr_en) begin
                case (ofs)
                    OFS_BASE: base <= wdata;
                    OFS_MASK: mask <= wdata[NUM_CH-1:0];
                    default:  ;
                endcase
            end
            if (rd_en) begin
                case (ofs)
                    OFS_BASE: rdata <= DATA_W'(base);
                    OFS_MASK: rdata <= DATA_W'(mask);
                    OFS_PEND: rdata <= DATA_W'(irq_lines);
                    default:  rdata <= '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/quart_cycle_fsm.sv
module quart_cycle_fsm
    import quart_pkg::*;
#(
    parameter int WAIT_STATES = 3,
    localparam int CNT_W = $clog2(WAIT_STATES + 1),
    localparam int LEN_W = $clog2(WAIT_STATES + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strb_n,
    input  logic              rw,
    input  dec_t              dec,
    output logic [NUM_CH-1:0] cs_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              ready,
    output logic              cfg_wr,
    output logic              cfg_rd
);

    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WAIT_STATES - 1);
    localparam logic [LEN_W-1:0] WS_LEN   = LEN_W'(WAIT_STATES);

    cyc_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       chan_q;
    logic             rw_q;
    logic             strobing;

    assign strobing = (state == ST_STROBE);
    assign rd_n     = !(strobing && rw_q);
    assign wr_n     = !(strobing && !rw_q);
    assign ready    = (state == ST_ACK);
    assign cfg_wr   = (state == ST_IDLE) && dec.ctrl_hit && !rw;
    assign cfg_rd   = (state == ST_IDLE) && dec.ctrl_hit && rw;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cs
        assign cs_n[g] = !(strobing && (chan_q == 2'(g)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            chan_q <= '0;
            rw_q   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (dec.uart_hit) begin
                        state  <= ST_STROBE;
                        cnt    <= '0;
                        chan_q <= dec.chan;
                        rw_q   <= rw;
                    end else if (dec.ctrl_hit) begin
                        state <= ST_ACK;
                    end
                end
                ST_STROBE: begin
                    if (cnt == LAST_CNT) state <= ST_ACK;
                    else                 cnt   <= cnt + 1'b1;
                end
                ST_ACK:  state <= strb_n ? ST_IDLE : ST_HOLD;
                ST_HOLD: if (strb_n) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    logic [LEN_W-1:0] strobe_len;
    always_ff @(posedge clk) begin
        if (rst)           strobe_len <= '0;
        else if (strobing) strobe_len <= strobe_len + 1'b1;
        else               strobe_len <= '0;
    end

    // R3
    cs_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~cs_n));

    // R4
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));

    // R4
    strobe_has_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_n || !wr_n) |-> !(&cs_n));

    // R5
    strobe_len_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && $past(strobing)) |-> (strobe_len == WS_LEN));

    // R6
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready);

    // R7
    held_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (ready && !strb_n) |=> ((&cs_n) && !ready));

endmodule

// File: rtl/quart_irq_merge.sv
module quart_irq_merge
    import quart_pkg::*;
(
    input  logic [NUM_CH-1:0] irq_lines,
    input  logic [NUM_CH-1:0] mask,
    output logic              irq_out
);

    assign irq_out = |(irq_lines & mask);

endmodule

// File: rtl/quad_uart_glue.sv
module quad_uart_glue
    import quart_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 32,
    parameter int WAIT_STATES = 3,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 24'hFFFFF0,
    localparam int BASE_W = ADDR_W - 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_strb_n,
    input  logic              bus_rw,
    input  logic [BASE_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic [NUM_CH-1:0] uart_cs_n,
    output logic              uart_rd_n,
    output logic              uart_wr_n,
    input  logic [NUM_CH-1:0] uart_irq,
    output logic              dsp_irq
);

    dec_t              dec;
    logic [BASE_W-1:0] base;
    logic [NUM_CH-1:0] mask;
    logic              cfg_wr;
    logic              cfg_rd;

    quart_decode #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_dec (
        .addr   (bus_addr),
        .strb_n (bus_strb_n),
        .base   (base),
        .dec    (dec)
    );

    quart_cycle_fsm #(.WAIT_STATES(WAIT_STATES)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .strb_n (bus_strb_n),
        .rw     (bus_rw),
        .dec    (dec),
        .cs_n   (uart_cs_n),
        .rd_n   (uart_rd_n),
        .wr_n   (uart_wr_n),
        .ready  (bus_ready),
        .cfg_wr (cfg_wr),
        .cfg_rd (cfg_rd)
    );

    quart_cfg_regs #(.BASE_W(BASE_W), .DATA_W(DATA_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_wr),
        .rd_en     (cfg_rd),
        .ofs       (dec.ofs),
        .wdata     (bus_wdata),
        .irq_lines (uart_irq),
        .base      (base),
        .mask      (mask),
        .rdata     (bus_rdata)
    );

    quart_irq_merge u_irq (
        .irq_lines (uart_irq),
        .mask      (mask),
        .irq_out   (dsp_irq)
    );

    // R2
    base_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (base == '0) |-> (&uart_cs_n));

    // R10
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (uart_irq == '0) |-> !dsp_irq);

    // R10
    mask_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !dsp_irq);

endmodule

// File: tb/quad_uart_glue_test.sv
`timescale 1ns/1ps
module quad_uart_glue_test;

    localparam int WS = 3;
    localparam int NV = 8;
    localparam logic [18:0] TBASE = 19'h12345;

    // {addr[23:0], rw, hit, chan[1:0]}
    localparam logic [27:0] VEC [NV] = '{
        {24'h2468A0, 1'b1, 1'b1, 2'd0},
        {24'h2468AF, 1'b0, 1'b1, 2'd1},
        {24'h2468B2, 1'b1, 1'b1, 2'd2},
        {24'h2468BD, 1'b0, 1'b1, 2'd3},
        {24'h2468C0, 1'b1, 1'b0, 2'd0},
        {24'h246880, 1'b0, 1'b0, 2'd0},
        {24'h2468BB, 1'b1, 1'b1, 2'd3},
        {24'h2468A5, 1'b0, 1'b1, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] bus_addr = '0;
    logic        bus_strb_n = 1'b1;
    logic        bus_rw = 1'b1;
    logic [18:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic [3:0]  uart_cs_n;
    logic        uart_rd_n;
    logic        uart_wr_n;
    logic [3:0]  uart_irq = '0;
    logic        dsp_irq;

    int checks = 0;
    int failures = 0;

    int cs_cnt [4];
    int cs_first;
    int rd_cnt, wr_cnt, rdy_cnt, rdy_at;
    logic [31:0] rdata_s;

    always #2.5 clk = ~clk;

    quad_uart_glue #(.WAIT_STATES(WS)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_strb_n(bus_strb_n),
        .bus_rw(bus_rw), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .uart_cs_n(uart_cs_n), .uart_rd_n(uart_rd_n),
        .uart_wr_n(uart_wr_n), .uart_irq(uart_irq), .dsp_irq(dsp_irq)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input logic [23:0] a, input logic rw, input logic [18:0] wd);
        for (int c = 0; c < 4; c++) cs_cnt[c] = 0;
        cs_first = 0; rd_cnt = 0; wr_cnt = 0; rdy_cnt = 0; rdy_at = 0; rdata_s = '0;
        @(negedge clk);
        bus_addr = a; bus_rw = rw; bus_wdata = wd; bus_strb_n = 1'b0;
        for (int i = 1; i <= WS + 5; i++) begin
            @(negedge clk);
            for (int c = 0; c < 4; c++) begin
                if (!uart_cs_n[c]) begin
                    cs_cnt[c]++;
                    if (cs_first == 0) cs_first = i;
                end
            end
            if (!uart_rd_n) rd_cnt++;
            if (!uart_wr_n) wr_cnt++;
            if (bus_ready) begin
                rdy_cnt++;
                if (rdy_at == 0) begin rdy_at = i; rdata_s = bus_rdata; end
            end
        end
        bus_strb_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic int total_cs();
        return cs_cnt[0] + cs_cnt[1] + cs_cnt[2] + cs_cnt[3];
    endfunction

    task automatic ctrl_access(input logic [1:0] ofs, input logic rw, input logic [18:0] wd, input string req);
        access({22'h3FFFFC, ofs}, rw, wd);
        check(rdy_cnt == 1 && rdy_at == 1, {req, " ctrl ready timing"}, rdy_at, 1);
        check(total_cs() == 0 && rd_cnt == 0 && wr_cnt == 0, {req, " ctrl no uart strobe"}, total_cs(), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state of outputs
        check(uart_cs_n == 4'hF, "R1 cs_n", uart_cs_n, 4'hF);
        check(uart_rd_n && uart_wr_n, "R1 strobes", {uart_rd_n, uart_wr_n}, 2'b11);
        check(!bus_ready, "R1 ready", bus_ready, 0);
        uart_irq = 4'hF; #1;
        check(!dsp_irq, "R1 irq with mask clear", dsp_irq, 0);
        uart_irq = 4'h0;
        ctrl_access(2'd0, 1'b1, '0, "R1");
        check(rdata_s == 0, "R1 base reads zero", rdata_s, 0);
        ctrl_access(2'd1, 1'b1, '0, "R1");
        check(rdata_s == 0, "R1 mask reads zero", rdata_s, 0);

        // R2 base zero disables decode
        access(24'h000008, 1'b1, '0);
        check(total_cs() == 0 && rdy_cnt == 0, "R2 base zero no response", total_cs() + rdy_cnt, 0);

        // R8 base write and readback
        ctrl_access(2'd0, 1'b0, TBASE, "R8");
        ctrl_access(2'd0, 1'b1, '0, "R8");
        check(rdata_s == 32'(TBASE), "R8 base readback", rdata_s, TBASE);

        // Vector walk: R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            logic [23:0] a;
            logic rw, hit;
            logic [1:0] ch;
            {a, rw, hit, ch} = VEC[v];
            access(a, rw, '0);
            if (hit) begin
                check(cs_cnt[ch] == WS && total_cs() == WS, "R3 channel select", cs_cnt[ch], WS);
                check(cs_first == 1, "R5 select start cycle", cs_first, 1);
                check(rw ? (rd_cnt == WS && wr_cnt == 0) : (wr_cnt == WS && rd_cnt == 0),
                      "R4 strobe direction", rw ? rd_cnt : wr_cnt, WS);
                check(rdy_cnt == 1 && rdy_at == WS + 1, "R6 ready after strobe", rdy_at, WS + 1);
                check(rd_cnt + wr_cnt == WS, "R7 no second access on held strobe", rd_cnt + wr_cnt, WS);
            end else begin
                check(total_cs() == 0 && rd_cnt == 0 && wr_cnt == 0 && rdy_cnt == 0,
                      "R2 address outside window", total_cs() + rdy_cnt, 0);
            end
        end

        // R8 mask write and readback, R10 merge
        ctrl_access(2'd1, 1'b0, 19'h00005, "R8");
        ctrl_access(2'd1, 1'b1, '0, "R8");
        check(rdata_s == 32'h5, "R8 mask readback", rdata_s, 5);
        uart_irq = 4'b1010; #1;
        check(!dsp_irq, "R10 masked lines stay quiet", dsp_irq, 0);
        uart_irq = 4'b0100; #1;
        check(dsp_irq, "R10 enabled line raises irq", dsp_irq, 1);
        uart_irq = 4'b0001; #1;
        check(dsp_irq, "R10 channel A enabled", dsp_irq, 1);

        // R9 pending vector, channel A in bit 0
        ctrl_access(2'd2, 1'b1, '0, "R9");
        check(rdata_s == 32'h1, "R9 pending channel A", rdata_s, 1);
        uart_irq = 4'b1010;
        ctrl_access(2'd2, 1'b1, '0, "R9");
        check(rdata_s == 32'hA, "R9 pending raw lines", rdata_s, 32'hA);
        ctrl_access(2'd2, 1'b0, 19'h7FFFF, "R9");
        ctrl_access(2'd3, 1'b0, 19'h7FFFF, "R9");
        ctrl_access(2'd1, 1'b1, '0, "R9");
        check(rdata_s == 32'h5, "R9 write to read-only keeps mask", rdata_s, 5);
        ctrl_access(2'd0, 1'b1, '0, "R9");
        check(rdata_s == 32'(TBASE), "R9 write to read-only keeps base", rdata_s, TBASE);
        ctrl_access(2'd3, 1'b1, '0, "R8");
        check(rdata_s == 0, "R8 offset 3 reads zero", rdata_s, 0);
        uart_irq = 4'h0;

        // R11 control priority over channel window
        ctrl_access(2'd0, 1'b0, 19'h7FFFF, "R11");
        ctrl_access(2'd0, 1'b1, '0, "R11");
        check(rdata_s == 32'h7FFFF, "R11 control read wins", rdata_s, 32'h7FFFF);
        access(24'hFFFFE0, 1'b1, '0);
        check(cs_cnt[0] == WS && rdy_at == WS + 1, "R11 channel still reachable near window", cs_cnt[0], WS);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule